// File: doc/BRIEF.md
# Double-Precision to 32-bit Signed Saturating Converter

This block turns a 64-bit IEEE-754 binary64 operand into a 32-bit two's-complement value in one registered stage. A mode bit chooses how the 32-bit output is read. In integer mode it is a plain signed integer. In fraction mode it is a signed Q1.31 fraction, which means the operand is scaled by 2^31 before rounding. Rounding follows a 2-bit mode input. Values that do not fit clamp to the nearest 32-bit extreme.

Special operands have fixed outcomes. A NaN gives zero, an infinity gives the extreme that matches its sign, and a subnormal gives zero. All three are reported as invalid. The block raises invalid and inexact status flags. It also exports the first discarded bit and the OR of all lower discarded bits, so trap software can finish a rounding step. Two exception-request lines are gated by enable inputs. When the inexact trap is enabled, the written result is the value truncated toward zero instead of the rounded one.

The block sits in an execution pipe. It takes one operand per cycle and answers one cycle later. Register-file writes and trap vectoring belong to the surrounding logic.

Top module: `f64_to_s32_cvt`

## Requirements
- R1: After reset, and in any cycle following one with `inValid` low, `outValid`, `resWe`, `flagInv`, `flagInx`, `invReq`, `rndReq`, `guardBit` and `stickyBit` are all 0.
- R2: An operand accepted with `inValid` high produces its outputs, with `outValid` high, on the next clock edge. With `fracMode` = 1 the converted quantity is the operand times 2^31. With `fracMode` = 0 it is the operand itself.
- R3: The converted quantity is rounded to an integer according to `rndMode`: 00 = nearest with ties to even, 01 = toward zero, 10 = toward +infinity, 11 = toward -infinity.
- R4: If the rounded value exceeds 2^31-1, the result is 0x7FFFFFFF. If it is below -2^31, the result is 0x80000000. Either case raises `flagInv`.
- R5: A NaN (exponent all ones, mantissa nonzero) gives 0. +infinity gives 0x7FFFFFFF and -infinity gives 0x80000000. A subnormal (exponent 0, mantissa nonzero) gives 0. All of these raise `flagInv`. Both +0 and -0 give 0 with no flag raised.
- R6: Whenever `flagInv` is high, `guardBit`, `stickyBit` and `flagInx` are 0.
- R7: `invReq` equals `flagInv` AND `invEn`. `resWe` is low exactly when `invReq` is high.
- R8: `flagInx` is high when a finite normal operand converts without overflow but the converted quantity is not an integer.
- R9: For every valid conversion that is not invalid, `guardBit` is the first bit below the integer point of the magnitude and `stickyBit` is the OR of all lower bits. When `flagInx` and `inxEn` are both high, `rndReq` is raised and the result is the converted quantity truncated toward zero. Otherwise `rndReq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand present this cycle |
| opA | input | 64 | binary64 operand |
| fracMode | input | 1 | 1 = Q1.31 fraction result, 0 = integer result |
| rndMode | input | 2 | Rounding mode (see R3) |
| invEn | input | 1 | Invalid-exception enable |
| inxEn | input | 1 | Inexact-exception enable |
| outValid | output | 1 | Outputs belong to an accepted operand |
| result | output | 32 | Converted signed value |
| resWe | output | 1 | Result may be written back |
| flagInv | output | 1 | Invalid status |
| flagInx | output | 1 | Inexact status |
| guardBit | output | 1 | First discarded bit |
| stickyBit | output | 1 | OR of remaining discarded bits |
| invReq | output | 1 | Invalid exception request |
| rndReq | output | 1 | Round exception request |

## Verification
The hardest situations to reach are the ones where rounding itself causes overflow. One example is 2147483647.5, which is in range when truncated but out of range after rounding up. The other hard situations are the exact-tie cases at the last integer position of the fraction format. The stimulus reaches them directly by building operands around ±2^31 in integer mode and odd multiples of 2^-32 in fraction mode. It then sweeps each one across all four rounding modes, both result modes and all four enable combinations. A reference model written with real arithmetic predicts every output.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_ZERO = 2'b01,
    RND_POS  = 2'b10,
    RND_NEG  = 2'b11
  } rndMode_e;

  // Strobes from control to the datapath result mux
  typedef struct packed {
    logic forceZero;
    logic saturate;
    logic useTrunc;
    logic clearGs;
  } cvtStrobe_t;

endpackage

// File: rtl/cvt_datapath.sv
module cvt_datapath
  import cvt_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int OUT_W = 32,
  parameter int FRAC_SHIFT = OUT_W - 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic [EXP_W+MAN_W:0]   opA,
  input  logic                   fracMode,
  input  logic [1:0]             rndMode,
  input  cvtStrobe_t             strobe,
  output logic                   isZero,
  output logic                   isDenorm,
  output logic                   isInf,
  output logic                   isNaN,
  output logic                   ovf,
  output logic                   lossG,
  output logic                   lossS,
  output logic [OUT_W-1:0]       result,
  output logic                   guardBit,
  output logic                   stickyBit
);
  localparam int OP_W   = 1 + EXP_W + MAN_W;
  localparam int SIG_W  = MAN_W + 1;
  localparam int LOW_W  = SIG_W + 2;
  localparam int WIDE_W = SIG_W + LOW_W;
  localparam int INT_W  = OUT_W + 1;
  localparam int SH_W   = EXP_W + 3;
  localparam int SHU_W  = $clog2(LOW_W + 1);
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam logic [INT_W:0] MAG_NEG = (INT_W + 1)'(1) << (OUT_W - 1);
  localparam logic [INT_W:0] MAG_POS = MAG_NEG - 1'b1;
  localparam logic [OUT_W-1:0] SAT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] SAT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic [EXP_W-1:0] expF;
  logic [MAN_W-1:0] manF;
  logic             isNeg;
  logic signed [SH_W-1:0] unbExp, shAmt;
  logic             bigExp, hiNz;
  logic [SHU_W-1:0] shUse;
  logic [WIDE_W-1:0] wide;
  logic [INT_W-1:0] intPart;
  logic             inc;
  logic [INT_W:0]   rndMag;
  logic [OUT_W-1:0] magSel, resNext;

  assign expF     = opA[OP_W-2 -: EXP_W];
  assign manF     = opA[MAN_W-1:0];
  assign isNeg    = opA[OP_W-1];
  assign isZero   = (expF == '0) && (manF == '0);
  assign isDenorm = (expF == '0) && (manF != '0);
  assign isInf    = (&expF) && (manF == '0);
  assign isNaN    = (&expF) && (manF != '0);

  always_comb begin
    unbExp = SH_W'(expF) - SH_W'(BIAS) + (fracMode ? SH_W'(FRAC_SHIFT) : SH_W'(0));
    shAmt  = SH_W'(MAN_W) - unbExp;
    bigExp = unbExp >= $signed(SH_W'(OUT_W));
    if (bigExp)                              shUse = '0;
    else if (shAmt > $signed(SH_W'(LOW_W)))  shUse = SHU_W'(LOW_W);
    else                                     shUse = SHU_W'(shAmt);
  end

  assign wide    = {1'b1, manF, {LOW_W{1'b0}}} >> shUse;
  assign intPart = wide[LOW_W +: INT_W];
  assign hiNz    = |wide[WIDE_W-1:LOW_W+INT_W];
  assign lossG   = wide[LOW_W-1];
  assign lossS   = |wide[LOW_W-2:0];

  always_comb begin
    case (rndMode_e'(rndMode))
      RND_NEAR: inc = lossG && (lossS || intPart[0]);
      RND_ZERO: inc = 1'b0;
      RND_POS:  inc = (lossG || lossS) && !isNeg;
      default:  inc = (lossG || lossS) && isNeg;
    endcase
  end

  assign rndMag = {1'b0, intPart} + (INT_W + 1)'(inc);
  assign ovf    = bigExp || hiNz || (isNeg ? (rndMag > MAG_NEG) : (rndMag > MAG_POS));

  always_comb begin
    magSel = strobe.useTrunc ? intPart[OUT_W-1:0] : rndMag[OUT_W-1:0];
    if (strobe.forceZero)     resNext = '0;
    else if (strobe.saturate) resNext = isNeg ? SAT_MIN : SAT_MAX;
    else                      resNext = isNeg ? (~magSel + 1'b1) : magSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result    <= '0;
      guardBit  <= 1'b0;
      stickyBit <= 1'b0;
    end else begin
      result    <= inValid ? resNext : result;
      guardBit  <= inValid && !strobe.clearGs && lossG;
      stickyBit <= inValid && !strobe.clearGs && lossS;
    end
  end

  // R4
  sat_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strobe.saturate) |=> (result[OUT_W-1] == $past(isNeg)));
endmodule

// File: rtl/cvt_ctrl.sv
module cvt_ctrl
  import cvt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       invEn,
  input  logic       inxEn,
  input  logic       isZero,
  input  logic       isDenorm,
  input  logic       isInf,
  input  logic       isNaN,
  input  logic       ovf,
  input  logic       lossG,
  input  logic       lossS,
  output cvtStrobe_t strobe,
  output logic       outValid,
  output logic       resWe,
  output logic       flagInv,
  output logic       flagInx,
  output logic       invReq,
  output logic       rndReq
);
  logic isNormal, invalid, inexact;

  assign isNormal = !isZero && !isDenorm && !isInf && !isNaN;
  assign invalid  = isInf || isNaN || isDenorm || (isNormal && ovf);
  assign inexact  = isNormal && !ovf && (lossG || lossS);

  always_comb begin
    strobe.forceZero = isZero || isNaN || isDenorm;
    strobe.saturate  = isInf || (isNormal && ovf);
    strobe.useTrunc  = inexact && inxEn;
    strobe.clearGs   = invalid || isZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      resWe    <= 1'b0;
      flagInv  <= 1'b0;
      flagInx  <= 1'b0;
      invReq   <= 1'b0;
      rndReq   <= 1'b0;
    end else begin
      outValid <= inValid;
      resWe    <= inValid && !(invalid && invEn);
      flagInv  <= inValid && invalid;
      flagInx  <= inValid && inexact;
      invReq   <= inValid && invalid && invEn;
      rndReq   <= inValid && inexact && inxEn;
    end
  end

  // R7
  inv_trap_chk: assert property (@(posedge clk) disable iff (!rstN)
    invReq |-> (flagInv && !resWe));
  // R9
  rnd_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    rndReq |-> (flagInx && resWe));
  // R6
  inv_inx_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagInv |-> !flagInx);
endmodule

// File: rtl/f64_to_s32_cvt.sv
module f64_to_s32_cvt
  import cvt_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int OUT_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [EXP_W+MAN_W:0] opA,
  input  logic                 fracMode,
  input  logic [1:0]           rndMode,
  input  logic                 invEn,
  input  logic                 inxEn,
  output logic                 outValid,
  output logic [OUT_W-1:0]     result,
  output logic                 resWe,
  output logic                 flagInv,
  output logic                 flagInx,
  output logic                 guardBit,
  output logic                 stickyBit,
  output logic                 invReq,
  output logic                 rndReq
);
  localparam int FRAC_SHIFT = OUT_W - 1;

  cvtStrobe_t strobe;
  logic isZero, isDenorm, isInf, isNaN, ovf, lossG, lossS;

  cvt_datapath #(
    .EXP_W(EXP_W), .MAN_W(MAN_W), .OUT_W(OUT_W), .FRAC_SHIFT(FRAC_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA),
    .fracMode(fracMode), .rndMode(rndMode), .strobe(strobe),
    .isZero(isZero), .isDenorm(isDenorm), .isInf(isInf), .isNaN(isNaN),
    .ovf(ovf), .lossG(lossG), .lossS(lossS),
    .result(result), .guardBit(guardBit), .stickyBit(stickyBit)
  );

  cvt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .invEn(invEn), .inxEn(inxEn),
    .isZero(isZero), .isDenorm(isDenorm), .isInf(isInf), .isNaN(isNaN),
    .ovf(ovf), .lossG(lossG), .lossS(lossS), .strobe(strobe),
    .outValid(outValid), .resWe(resWe), .flagInv(flagInv), .flagInx(flagInx),
    .invReq(invReq), .rndReq(rndReq)
  );

  // R6
  gs_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagInv |-> (!guardBit && !stickyBit));
  // R9
  rnd_gs_chk: assert property (@(posedge clk) disable iff (!rstN)
    rndReq |-> (guardBit || stickyBit));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!resWe && !flagInv && !flagInx && !invReq && !rndReq));
endmodule

// File: tb/f64_to_s32_cvt_tb.sv
`timescale 1ns/1ps
module f64_to_s32_cvt_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [63:0] opA = '0;
  logic fracMode = 1'b0;
  logic [1:0] rndMode = 2'b00;
  logic invEn = 1'b0, inxEn = 1'b0;
  logic outValid, resWe, flagInv, flagInx, guardBit, stickyBit, invReq, rndReq;
  logic [31:0] result;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  logic [31:0] expRes;
  logic expWe, expInv, expInx, expG, expS, expInvReq, expRndReq;
  string resTag;

  always #4 clk = ~clk;

  f64_to_s32_cvt u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .fracMode(fracMode),
    .rndMode(rndMode), .invEn(invEn), .inxEn(inxEn), .outValid(outValid),
    .result(result), .resWe(resWe), .flagInv(flagInv), .flagInx(flagInx),
    .guardBit(guardBit), .stickyBit(stickyBit), .invReq(invReq), .rndReq(rndReq)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s op=%h fm=%0d rm=%0d en=%0d%0d act=%h exp=%h",
               tag, what, opA, fracMode, rndMode, invEn, inxEn, act, exp);
    end
  endtask

  task automatic refModel(input logic [63:0] b, input logic fm, input logic [1:0] rm,
                          input logic ie, input logic xe);
    logic [10:0] e;
    logic [51:0] man;
    real v, mag, rem;
    longint fl, rmag;
    logic neg, g, s, ovf;
    e = b[62:52]; man = b[51:0];
    g = 0; s = 0; ovf = 0; fl = 0; rmag = 0; neg = b[63];
    expInv = 0; expInx = 0; expG = 0; expS = 0; expRes = '0;
    if (e == 0 && man == 0) begin
      resTag = "R5";
    end else if (e == 0) begin
      expInv = 1; resTag = "R5";
    end else if (e == 11'h7FF) begin
      expInv = 1; resTag = "R5";
      expRes = (man != 0) ? 32'h0 : (b[63] ? 32'h8000_0000 : 32'h7FFF_FFFF);
    end else begin
      v = $bitstoreal(b);
      if (fm) v = v * 2147483648.0;
      mag = neg ? -v : v;
      if (mag >= 1099511627776.0) ovf = 1;
      else begin
        fl = longint'(mag);
        if (real'(fl) > mag) fl = fl - 1;
        rem = mag - real'(fl);
        g = (rem >= 0.5);
        s = g ? (rem > 0.5) : (rem > 0.0);
        case (rm)
          2'b00:   rmag = fl + ((g && (s || fl[0])) ? 1 : 0);
          2'b01:   rmag = fl;
          2'b10:   rmag = fl + ((!neg && (g || s)) ? 1 : 0);
          default: rmag = fl + ((neg && (g || s)) ? 1 : 0);
        endcase
        ovf = neg ? (rmag > 64'sd2147483648) : (rmag > 64'sd2147483647);
      end
      if (ovf) begin
        expInv = 1; resTag = "R4";
        expRes = neg ? 32'h8000_0000 : 32'h7FFF_FFFF;
      end else begin
        expG = g; expS = s; expInx = g || s;
        if (expInx && xe) begin
          resTag = "R9"; expRes = 32'(neg ? -fl : fl);
        end else begin
          resTag = fm ? "R2" : "R3"; expRes = 32'(neg ? -rmag : rmag);
        end
      end
    end
    expInvReq = expInv && ie;
    expWe = !expInvReq;
    expRndReq = expInx && xe;
  endtask

  task automatic runOne(input logic [63:0] b, input logic fm, input logic [1:0] rm,
                        input logic ie, input logic xe);
    opA = b; fracMode = fm; rndMode = rm; invEn = ie; inxEn = xe; inValid = 1'b1;
    refModel(b, fm, rm, ie, xe);
    @(negedge clk);
    chk("R2", "outValid", 64'(outValid), 64'd1);
    if (expWe) chk(resTag, "result", 64'(result), 64'(expRes));
    chk("R7", "resWe", 64'(resWe), 64'(expWe));
    chk("R7", "invReq", 64'(invReq), 64'(expInvReq));
    chk("R6", "flagInv", 64'(flagInv), 64'(expInv));
    chk("R8", "flagInx", 64'(flagInx), 64'(expInx));
    chk(expInv ? "R6" : "R9", "guard", 64'(guardBit), 64'(expG));
    chk(expInv ? "R6" : "R9", "sticky", 64'(stickyBit), 64'(expS));
    chk("R9", "rndReq", 64'(rndReq), 64'(expRndReq));
  endtask

  task automatic sweep(input logic [63:0] b);
    for (int fm = 0; fm < 2; fm++)
      for (int rm = 0; rm < 4; rm++)
        for (int en = 0; en < 4; en++)
          runOne(b, fm[0], rm[1:0], en[1], en[0]);
  endtask

  task automatic sweepReal(input real r);
    sweep($realtobits(r));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErr++; nChecks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "outValid", 64'(outValid), 0);
    chk("R1", "flags", 64'({resWe, flagInv, flagInx, invReq, rndReq}), 0);
    chk("R1", "gs", 64'({guardBit, stickyBit}), 0);
    rstN = 1'b1;
    @(negedge clk);
    // Specials: zeros, subnormals, infinities, NaNs (R5)
    sweep(64'h0000_0000_0000_0000);
    sweep(64'h8000_0000_0000_0000);
    sweep(64'h0000_0000_0000_0001);
    sweep(64'h800F_FFFF_FFFF_FFFF);
    sweep(64'h7FF0_0000_0000_0000);
    sweep(64'hFFF0_0000_0000_0000);
    sweep(64'h7FF8_0000_0000_0000);
    sweep(64'hFFF0_0000_0000_0001);
    // Quarter steps and 1/32 steps (R2, R3)
    for (int i = -40; i <= 40; i++) begin
      sweepReal(i * 0.25);
      sweepReal(i / 32.0);
    end
    // Fraction-mode ties at the last bit (R3)
    for (int k = 0; k < 8; k++) begin
      sweepReal((2 * k + 1) / 4294967296.0);
      sweepReal(-(2 * k + 1) / 4294967296.0);
    end
    // Saturation boundaries (R4)
    sweepReal(2147483647.0);
    sweepReal(2147483647.4);
    sweepReal(2147483647.5);
    sweepReal(2147483648.0);
    sweepReal(-2147483648.0);
    sweepReal(-2147483648.4);
    sweepReal(-2147483648.5);
    sweepReal(-2147483649.0);
    sweepReal(1.0e10);
    sweepReal(-1.0e10);
    sweepReal(3.0e300);
    sweepReal(-3.0e300);
    sweepReal(1.0e-30);
    sweepReal(-1.0e-30);
    sweepReal(1.0 - 1.0 / 4294967296.0);
    sweepReal(1.0 - 1.0 / 8589934592.0);
    sweepReal(-1.0 - 1.0 / 8589934592.0);
    sweepReal(-1.0 - 1.0 / 4294967296.0);
    sweepReal(123456.789);
    sweepReal(-98765.4321);
    // R1: idle cycle clears outputs
    inValid = 1'b0;
    @(negedge clk);
    chk("R1", "idle outValid", 64'(outValid), 0);
    chk("R1", "idle flags", 64'({resWe, flagInv, flagInx, invReq, rndReq}), 0);
    chk("R1", "idle gs", 64'({guardBit, stickyBit}), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule